// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block is the general-purpose register storage of a small processor datapath. It holds a parameterised set of word-wide registers (32 registers of 32 bits by default) that two operand read ports can look up independently. A single write port takes an index, a data word and an enable. The decode stage drives both read indices and receives the operands with no clock delay. The writeback stage presents its result, and the falling clock edge commits it.

Committing on the falling edge lets a result written in the first half of a cycle be read by the decode logic in the second half of that same cycle. Register 0 is a constant zero source: it reads zero on both ports whatever has been written to it. A synchronous active-low reset, sampled on the same falling edge as writes, clears every other register.

Top module: `dreg_file`

## Requirements
- R1: The file holds 32 registers of 32 bits, addressed by indices 0 to 31. A word written to any index from 1 to 31 reads back unchanged at that index on either read port.
- R2: Index 0 always reads as all zeros on both read ports. A write addressed to index 0 is discarded, including the read of index 0 in the same cycle as that write.
- R3: A register changes only when `wr_en` is 1 at a falling clock edge. With `wr_en` at 0, every register keeps its value whatever `wr_idx` and `wr_data` carry.
- R4: A write is committed on the falling clock edge. Between the rising edge and the falling edge, a read of the register being written returns the old value. After the falling edge it returns the new value.
- R5: When `rst_n` is 0 at a falling edge, registers 1 to 31 are cleared to zero. Reset takes priority over a write presented at that same edge.
- R6: The two read ports are combinational and independent. When both ports select the same index they return the same value.
- R7: A later write to a register replaces the earlier value completely, with no bits of the old value kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write enable, 1 = write |
| wr_idx | input | 5 | Index of the register to write |
| wr_data | input | 32 | Word to write |
| rd_idx_a | input | 5 | Index for read port A |
| rd_data_a | output | 32 | Combinational value of register `rd_idx_a` |
| rd_idx_b | input | 5 | Index for read port B |
| rd_data_b | output | 32 | Combinational value of register `rd_idx_b` |

## Verification
The bench targets the following corner cases:

- **Write to index 0.** A write of all ones to index 0 is read back on both ports. A design that stored it, or decoded index 0 as a real register, would return ones there.
- **Read during write.** A register is sampled just before and just after the falling edge of its write. A rising-edge or transparent implementation shows the new value too early, and a design that is late shows the old value after the edge.
- **Disabled write.** Writes with `wr_en` at 0 are presented to live registers and the registers are then read back. A decoder that ignores the enable would corrupt them.
- **Reset.** A reset is issued while a write is held active, then all 32 registers are swept on both ports. A missed clear or a write that beats reset shows up as nonzero data.

A full sweep with a distinct pattern per register also exposes index aliasing between registers and between the two ports.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
// Package: shared sizing defaults for the register file.
// Assumes: the register count is a power of two so the index width is exact.
package rf_pkg;
    localparam int RF_DEF_REGS   = 32;
    localparam int RF_DEF_DATA_W = 32;
endpackage

// File: rtl/rf_wr_decode.sv
`timescale 1ns/1ps
// Module: rf_wr_decode
// Turns the write enable and index into one select line per writable register.
// Assumes: register 0 is never writable, so no select exists for it.
module rf_wr_decode #(
    parameter int NUM_REGS = rf_pkg::RF_DEF_REGS,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    output logic [NUM_REGS-1:1]   wr_sel
);
    // Purpose: raise at most one select, only for indices 1 and above.
    always_comb begin
        for (int k = 1; k < NUM_REGS; k++) begin
            wr_sel[k] = wr_en && (wr_idx == IDX_W'(k));
        end
    end
endmodule

// File: rtl/rf_cell.sv
`timescale 1ns/1ps
// Module: rf_cell
// One storage word, updated on the falling clock edge.
// Assumes: reset is synchronous, active low, and outranks the write select.
module rf_cell #(
    parameter int DATA_W = rf_pkg::RF_DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    // Purpose: clear on reset, else capture the write data when selected.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (sel) begin
            q <= din;
        end
    end
endmodule

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
// Module: rf_read_port
// Combinational word selector over the flattened register array.
// Assumes: slot 0 of the flat vector may hold anything; index 0 is forced to zero here.
module rf_read_port #(
    parameter int NUM_REGS = rf_pkg::RF_DEF_REGS,
    parameter int DATA_W   = rf_pkg::RF_DEF_DATA_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS*DATA_W-1:0] flat,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [DATA_W-1:0]          rd_data
);
    // Purpose: pick the addressed word, returning zero for index 0.
    always_comb begin
        if (rd_idx == '0) begin
            rd_data = '0;
        end else begin
            rd_data = flat[int'(rd_idx)*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/dreg_file.sv
`timescale 1ns/1ps
// Module: dreg_file
// Register file with two asynchronous read ports and one write port committed
// on the falling clock edge. Register 0 is a constant zero.
// Assumes: the writer meets setup to the falling edge; readers tolerate a
// combinational path from index to data.
module dreg_file #(
    parameter int NUM_REGS = rf_pkg::RF_DEF_REGS,
    parameter int DATA_W   = rf_pkg::RF_DEF_DATA_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_data_b
);
    logic [NUM_REGS-1:1]        wr_sel;
    logic [NUM_REGS*DATA_W-1:0] flat;

    rf_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_sel (wr_sel)
    );

    // Purpose: slot 0 holds no storage and is tied to zero.
    assign flat[DATA_W-1:0] = '0;

    // Purpose: one storage cell per writable register.
    for (genvar g = 1; g < NUM_REGS; g++) begin : g_cell
        rf_cell #(.DATA_W(DATA_W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (wr_sel[g]),
            .din   (wr_data),
            .q     (flat[g*DATA_W +: DATA_W])
        );
    end

    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_a (
        .flat    (flat),
        .rd_idx  (rd_idx_a),
        .rd_data (rd_data_a)
    );

    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_b (
        .flat    (flat),
        .rd_idx  (rd_idx_b),
        .rd_data (rd_data_b)
    );
endmodule

// File: rtl/rf_checker.sv
`timescale 1ns/1ps
// Module: rf_checker
// Port-level properties of dreg_file, attached by bind.
// Assumes: inputs change away from the falling edge.
module rf_checker #(
    parameter int NUM_REGS = rf_pkg::RF_DEF_REGS,
    parameter int DATA_W   = rf_pkg::RF_DEF_DATA_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [IDX_W-1:0]  rd_idx_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [IDX_W-1:0]  rd_idx_b,
    input logic [DATA_W-1:0] rd_data_b
);
    AST_ZERO_IDX_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_a == '0) |-> (rd_data_a == '0)); // R2
    AST_ZERO_IDX_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_b == '0) |-> (rd_data_b == '0)); // R2
    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_a == rd_idx_b) |-> (rd_data_a == rd_data_b)); // R6
    AST_WRITE_LANDS: assert property (@(negedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0) |=>
        ((rd_idx_a == $past(wr_idx)) |-> (rd_data_a == $past(wr_data)))); // R4
    AST_HOLD_NO_WRITE: assert property (@(negedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($stable(rd_idx_a) |-> $stable(rd_data_a))); // R3
    AST_RESET_CLEARS: assert property (@(negedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rd_data_a == '0 && rd_data_b == '0)); // R5
endmodule

bind dreg_file rf_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dreg_file.sv
`timescale 1ns/1ps
// Bench for dreg_file: vector table, then directed reset and corner tests.
module tb_dreg_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_idx_a = '0;
    logic [31:0] rd_data_a;
    logic [4:0]  rd_idx_b = '0;
    logic [31:0] rd_data_b;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    dreg_file dut (.*);

    typedef struct packed {
        logic        we;
        logic [4:0]  w;
        logic [31:0] d;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [31:0] ea;
        logic [31:0] eb;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 5'd5,  32'hDEAD_BEEF, 5'd5,  5'd0,  32'hDEAD_BEEF, 32'h0},          // R1
        '{1'b1, 5'd31, 32'h1234_5678, 5'd31, 5'd5,  32'h1234_5678, 32'hDEAD_BEEF},  // R1
        '{1'b1, 5'd0,  32'hFFFF_FFFF, 5'd0,  5'd0,  32'h0,         32'h0},          // R2
        '{1'b0, 5'd5,  32'h0,         5'd5,  5'd5,  32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R3 R6
        '{1'b1, 5'd1,  32'hA5A5_A5A5, 5'd1,  5'd31, 32'hA5A5_A5A5, 32'h1234_5678},  // R1
        '{1'b1, 5'd5,  32'h0000_0001, 5'd5,  5'd1,  32'h0000_0001, 32'hA5A5_A5A5},  // R7
        '{1'b0, 5'd1,  32'hFFFF_FFFF, 5'd1,  5'd2,  32'hA5A5_A5A5, 32'h0},          // R3
        '{1'b1, 5'd2,  32'h8000_0000, 5'd2,  5'd2,  32'h8000_0000, 32'h8000_0000}   // R6
    };

    function automatic logic [31:0] pat(input int i);
        if (i == 0) return 32'h0;
        return {8'(i), ~8'(i), 8'(i) ^ 8'h5A, 8'hC3};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive after a rising edge, so the next falling edge commits.
    task automatic drive(input logic we, input logic [4:0] w, input logic [31:0] d,
                         input logic [4:0] ra, input logic [4:0] rb);
        @(posedge clk);
        #2;
        wr_en = we; wr_idx = w; wr_data = d; rd_idx_a = ra; rd_idx_b = rb;
    endtask

    task automatic after_fall;
        @(negedge clk);
        #2;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
            $finish;
        end
    endtask

    initial begin
        // Reset while a write is held active: reset must win (R5).
        drive(1'b1, 5'd7, 32'hFFFF_0000, 5'd7, 5'd0);
        repeat (3) after_fall;
        drive(1'b0, 5'd0, 32'h0, 5'd7, 5'd0);
        rst_n = 1'b1;
        after_fall;
        check("R5 reset beats write", rd_data_a, 32'h0);
        for (int i = 0; i < 32; i++) begin
            drive(1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i));
            #2;
            check("R5 reset state A", rd_data_a, 32'h0);
            check("R5 reset state B", rd_data_b, 32'h0);
        end

        // Vector table.
        for (int v = 0; v < NVEC; v++) begin
            drive(VECS[v].we, VECS[v].w, VECS[v].d, VECS[v].ra, VECS[v].rb);
            after_fall;
            check("R1/R2/R3/R6/R7 vector A", rd_data_a, VECS[v].ea);
            check("R1/R2/R3/R6/R7 vector B", rd_data_b, VECS[v].eb);
        end

        // Read during write: old before the falling edge, new after (R4).
        drive(1'b1, 5'd5, 32'hCAFE_F00D, 5'd5, 5'd5);
        #3;
        check("R4 old value before fall", rd_data_a, 32'h0000_0001);
        after_fall;
        check("R4 new value after fall", rd_data_a, 32'hCAFE_F00D);
        check("R6 same index both ports", rd_data_b, 32'hCAFE_F00D);

        // Write to index 0, read 0 during that very cycle (R2).
        drive(1'b1, 5'd0, 32'h7777_7777, 5'd0, 5'd0);
        #3;
        check("R2 zero during write pre-fall", rd_data_a, 32'h0);
        after_fall;
        check("R2 zero during write post-fall", rd_data_b, 32'h0);

        // Fill every register with a distinct pattern, then sweep (R1 R7).
        for (int i = 1; i < 32; i++) begin
            drive(1'b1, 5'(i), pat(i), 5'(i), 5'd0);
        end
        for (int i = 0; i < 32; i++) begin
            drive(1'b0, 5'(i), 32'hFFFF_FFFF, 5'(i), 5'(31 - i));
            after_fall;
            check("R1 sweep A", rd_data_a, pat(i));
            check("R1 sweep B", rd_data_b, pat(31 - i));
        end

        // Disabled write across several indices leaves contents alone (R3).
        for (int i = 1; i < 32; i += 6) begin
            drive(1'b0, 5'(i), 32'h0BAD_0BAD, 5'(i), 5'(i));
            after_fall;
            check("R3 disabled write A", rd_data_a, pat(i));
        end

        // Mid-run reset clears everything (R5).
        drive(1'b0, 5'd0, 32'h0, 5'd9, 5'd31);
        rst_n = 1'b0;
        after_fall;
        drive(1'b0, 5'd0, 32'h0, 5'd9, 5'd31);
        rst_n = 1'b1;
        after_fall;
        check("R5 mid-run reset A", rd_data_a, 32'h0);
        check("R5 mid-run reset B", rd_data_b, 32'h0);

        finish_run();
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule